// File: doc/BRIEF.md
# Packed Signed Minimum Lane Unit

This block is a vector datapath that takes two operand vectors, splits them into 32-bit lanes, and compares each pair of lanes as two's-complement signed integers. The smaller value of each pair goes to a 256-bit destination. A two-bit mode input picks how many lanes are computed and what happens to the upper half of the destination. The choices are a legacy 128-bit form, an encoded 128-bit form and an encoded 256-bit form.

In the legacy form the current destination value acts as the first operand. Only the lower four lanes are computed, and the upper half passes through unchanged. The encoded 128-bit form takes two separate sources, computes four lanes and clears the upper half. The 256-bit form computes all eight lanes.

The block also raises an undefined-operation indication in two cases: the reserved mode code, or a length bit set in the encoded 128-bit form. In that case it suppresses the destination write and returns the old destination intact. Each operation is accepted on an input valid pulse. The result, the write enable and the indication are registered and appear on the next clock edge alongside an output valid.

Top module: `vmin_unit`

## Requirements
- R1: Each 32-bit lane is compared as a two's-complement signed value, so a lane with bit 31 set is smaller than any lane with bit 31 clear.
- R2: In each lane the first operand is chosen only when it is strictly less than the second; on equality or when greater, the second operand is chosen.
- R3: With in_mode = 2'b00 (legacy 128-bit), lanes 0..3 (bits 127:0) use in_dst as first operand and in_src2 as second, in_src1 has no effect, and result bits 255:128 equal in_dst bits 255:128.
- R4: With in_mode = 2'b01 and in_len = 0 (encoded 128-bit), lanes 0..3 use in_src1 and in_src2 and result bits 255:128 are zero.
- R5: With in_mode = 2'b10 (encoded 256-bit), all eight lanes (bits 255:0) are computed from in_src1 and in_src2.
- R6: With in_mode = 2'b01 and in_len = 1, out_undef is 1, out_wr_en is 0 and out_result equals in_dst in all 256 bits.
- R7: With in_mode = 2'b11 (reserved), out_undef is 1, out_wr_en is 0 and out_result equals in_dst in all 256 bits.
- R8: in_len has no effect in modes 2'b00 and 2'b10: no undefined indication is raised and the result is as in R3 and R5.
- R9: An operation accepted with in_valid at one rising edge is presented with out_valid = 1 exactly one edge later, with out_wr_en = 1 when no undefined indication is raised; back-to-back operations each appear on consecutive cycles.
- R10: out_wr_en and out_undef are 0 whenever out_valid is 0.
- R11: A synchronous active-high rst clears out_valid, out_wr_en and out_undef.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| in_mode | input | 2 | 00 legacy 128, 01 encoded 128, 10 encoded 256, 11 reserved |
| in_len | input | 1 | Vector length bit of the encoding |
| in_dst | input | 256 | Current destination contents |
| in_src1 | input | 256 | First source (encoded forms) |
| in_src2 | input | 256 | Second source |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 256 | Value to write to the destination |
| out_wr_en | output | 1 | Destination write enable |
| out_undef | output | 1 | Undefined-operation indication |

## Verification
The hardest situation to reach is one that tells a signed compare apart from an unsigned one, in every lane position at once. Random data rarely lines up opposite signs in all lanes. Directed vectors therefore place the most-negative value against the most-positive one and alternate which operand holds the negative value from lane to lane. A second vector rotates a single negative lane through all eight positions. The merge paths are reached by giving in_src1 and the upper half of in_dst distinct marker patterns. A leak from either into a result then shows up at the outputs.

// File: rtl/vmin_pkg.sv
package vmin_pkg;
   typedef enum logic [1:0] {
      MODE_LEG128 = 2'b00,
      MODE_ENC128 = 2'b01,
      MODE_ENC256 = 2'b10,
      MODE_RSVD   = 2'b11
   } vmode_e;

   // compare implementations selectable per instance
   localparam int CMP_NATIVE = 0;
   localparam int CMP_BIASED = 1;
endpackage

// File: rtl/vmin_lane.sv
module vmin_lane #(
   parameter int LANE_W    = 32,
   parameter int CMP_STYLE = vmin_pkg::CMP_NATIVE
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   output logic [LANE_W-1:0] y
);
   localparam int MSB = LANE_W - 1;

   logic a_lt_b;

   generate
      if (CMP_STYLE == vmin_pkg::CMP_BIASED) begin : g_biased
         // flip sign bits so an unsigned compare orders signed values
         logic [LANE_W-1:0] a_b, b_b;
         always_comb begin
            a_b = {~a[MSB], a[MSB-1:0]};
            b_b = {~b[MSB], b[MSB-1:0]};
            a_lt_b = (a_b < b_b);
         end
      end else begin : g_native
         always_comb a_lt_b = ($signed(a) < $signed(b));
      end
   endgenerate

   // strict less-than picks a; ties fall to b
   always_comb y = a_lt_b ? a : b;
endmodule

// File: rtl/vmin_lane_array.sv
module vmin_lane_array #(
   parameter int LANE_W    = 32,
   parameter int NUM_LANES = 8,
   parameter int CMP_STYLE = vmin_pkg::CMP_NATIVE,
   localparam int VEC_W    = LANE_W * NUM_LANES
) (
   input  logic [VEC_W-1:0] a,
   input  logic [VEC_W-1:0] b,
   output logic [VEC_W-1:0] y
);
   generate
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         vmin_lane #(
            .LANE_W    (LANE_W),
            .CMP_STYLE (CMP_STYLE)
         ) u_lane (
            .a (a[g*LANE_W +: LANE_W]),
            .b (b[g*LANE_W +: LANE_W]),
            .y (y[g*LANE_W +: LANE_W])
         );
      end
   endgenerate
endmodule

// File: rtl/vmin_decode.sv
module vmin_decode (
   input  logic [1:0] mode,
   input  logic       len,
   output logic       undef,
   output logic       dst_is_a,
   output logic       keep_hi,
   output logic       zero_hi
);
   import vmin_pkg::*;

   vmode_e m;

   always_comb begin
      m        = vmode_e'(mode);
      undef    = 1'b0;
      dst_is_a = 1'b0;
      keep_hi  = 1'b0;
      zero_hi  = 1'b0;
      unique case (m)
         MODE_LEG128: begin
            dst_is_a = 1'b1;
            keep_hi  = 1'b1;
         end
         MODE_ENC128: begin
            undef   = len;
            zero_hi = 1'b1;
         end
         MODE_ENC256: ;
         MODE_RSVD:   undef = 1'b1;
         default:     undef = 1'b1;
      endcase
   end
endmodule

// File: rtl/vmin_unit.sv
module vmin_unit #(
   parameter int LANE_W    = 32,
   parameter int NUM_LANES = 8,
   parameter int CMP_STYLE = vmin_pkg::CMP_NATIVE,
   localparam int VEC_W    = LANE_W * NUM_LANES,
   localparam int HALF_W   = VEC_W / 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [1:0]       in_mode,
   input  logic             in_len,
   input  logic [VEC_W-1:0] in_dst,
   input  logic [VEC_W-1:0] in_src1,
   input  logic [VEC_W-1:0] in_src2,
   output logic             out_valid,
   output logic [VEC_W-1:0] out_result,
   output logic             out_wr_en,
   output logic             out_undef
);
   generate
      if (NUM_LANES < 2 || (NUM_LANES % 2) != 0) begin : g_bad_lanes
         $error("vmin_unit: NUM_LANES must be even and at least 2");
      end
      if (LANE_W < 2) begin : g_bad_width
         $error("vmin_unit: LANE_W must be at least 2");
      end
      if (CMP_STYLE != vmin_pkg::CMP_NATIVE && CMP_STYLE != vmin_pkg::CMP_BIASED) begin : g_bad_style
         $error("vmin_unit: unknown CMP_STYLE");
      end
   endgenerate

   logic             dec_undef, dec_dst_a, dec_keep_hi, dec_zero_hi;
   logic [VEC_W-1:0] op_a, lane_y, merged;

   vmin_decode u_dec (
      .mode     (in_mode),
      .len      (in_len),
      .undef    (dec_undef),
      .dst_is_a (dec_dst_a),
      .keep_hi  (dec_keep_hi),
      .zero_hi  (dec_zero_hi)
   );

   always_comb op_a = dec_dst_a ? in_dst : in_src1;

   vmin_lane_array #(
      .LANE_W    (LANE_W),
      .NUM_LANES (NUM_LANES),
      .CMP_STYLE (CMP_STYLE)
   ) u_arr (
      .a (op_a),
      .b (in_src2),
      .y (lane_y)
   );

   always_comb begin
      if (dec_undef) begin
         merged = in_dst;
      end else begin
         merged[HALF_W-1:0] = lane_y[HALF_W-1:0];
         if (dec_keep_hi)
            merged[VEC_W-1:HALF_W] = in_dst[VEC_W-1:HALF_W];
         else if (dec_zero_hi)
            merged[VEC_W-1:HALF_W] = '0;
         else
            merged[VEC_W-1:HALF_W] = lane_y[VEC_W-1:HALF_W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_wr_en <= 1'b0;
         out_undef <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_wr_en <= in_valid & ~dec_undef;
         out_undef <= in_valid & dec_undef;
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid) out_result <= merged;
   end
endmodule

// File: rtl/vmin_unit_chk.sv
module vmin_unit_chk #(
   parameter int VEC_W = 256
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [1:0]       in_mode,
   input logic             in_len,
   input logic [VEC_W-1:0] in_dst,
   input logic             out_valid,
   input logic [VEC_W-1:0] out_result,
   input logic             out_wr_en,
   input logic             out_undef
);
   localparam int HALF_W = VEC_W / 2;

   assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_idle_follows_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (!out_wr_en && !out_undef));

   assert_undef_blocks_write_R6: assert property (@(posedge clk) disable iff (rst)
      out_undef |-> !out_wr_en);

   assert_reserved_undef_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_mode == 2'b11) |=> (out_undef && out_result == $past(in_dst)));

   assert_len_undef_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_mode == 2'b01 && in_len) |=> (out_undef && out_result == $past(in_dst)));

   assert_legacy_keeps_hi_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_mode == 2'b00) |=>
         (out_wr_en && out_result[VEC_W-1:HALF_W] == $past(in_dst[VEC_W-1:HALF_W])));

   assert_enc128_zero_hi_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_mode == 2'b01 && !in_len) |=>
         (out_wr_en && out_result[VEC_W-1:HALF_W] == '0));

   assert_len_ignored_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_mode == 2'b10) |=> (out_wr_en && !out_undef));
endmodule

bind vmin_unit vmin_unit_chk #(.VEC_W(VEC_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .in_mode    (in_mode),
   .in_len     (in_len),
   .in_dst     (in_dst),
   .out_valid  (out_valid),
   .out_result (out_result),
   .out_wr_en  (out_wr_en),
   .out_undef  (out_undef)
);

// File: tb/tb_vmin_unit.sv
module tb_vmin_unit;
   localparam int W = 256;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [1:0]   in_mode;
   logic         in_len;
   logic [W-1:0] in_dst, in_src1, in_src2;
   logic         out_valid, out_wr_en, out_undef;
   logic [W-1:0] out_result;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   vmin_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode), .in_len(in_len),
      .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
      .out_valid(out_valid), .out_result(out_result),
      .out_wr_en(out_wr_en), .out_undef(out_undef)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         fails++;
         $display("FAIL watchdog: run exceeded cycle limit");
         $display("  test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

   // per-lane reference: sign bits decide first, magnitudes only on equal signs
   function automatic logic [31:0] ref_lane(input logic [31:0] a, input logic [31:0] b);
      logic first_smaller;
      if (a[31] != b[31]) first_smaller = a[31];
      else                first_smaller = (a[30:0] < b[30:0]);
      return first_smaller ? a : b;
   endfunction

   function automatic logic [W-1:0] ref_result(input logic [1:0] m, input logic l,
         input logic [W-1:0] d, input logic [W-1:0] s1, input logic [W-1:0] s2);
      logic [W-1:0] r;
      r = d;
      if (m == 2'b00) begin
         for (int i = 0; i < 4; i++) r[i*32 +: 32] = ref_lane(d[i*32 +: 32], s2[i*32 +: 32]);
      end else if (m == 2'b01 && !l) begin
         r = '0;
         for (int i = 0; i < 4; i++) r[i*32 +: 32] = ref_lane(s1[i*32 +: 32], s2[i*32 +: 32]);
      end else if (m == 2'b10) begin
         for (int i = 0; i < 8; i++) r[i*32 +: 32] = ref_lane(s1[i*32 +: 32], s2[i*32 +: 32]);
      end
      return r;
   endfunction

   task automatic chk1(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic chkv(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drive at a falling edge, sample at the next falling edge (one register)
   task automatic exec(input string req, input logic [1:0] m, input logic l,
         input logic [W-1:0] d, input logic [W-1:0] s1, input logic [W-1:0] s2);
      logic undef_exp;
      undef_exp = (m == 2'b11) || (m == 2'b01 && l);
      in_valid = 1'b1; in_mode = m; in_len = l;
      in_dst = d; in_src1 = s1; in_src2 = s2;
      @(negedge clk);
      chk1(req, "out_valid", out_valid, 1'b1);
      chk1(req, "out_wr_en", out_wr_en, !undef_exp);
      chk1(req, "out_undef", out_undef, undef_exp);
      chkv(req, "out_result", out_result, ref_result(m, l, d, s1, s2));
   endtask

   task automatic idle(input string req);
      in_valid = 1'b0;
      in_src1 = {8{32'hDEAD_0001}};
      in_mode = 2'b11;
      @(negedge clk);
      chk1(req, "idle out_valid", out_valid, 1'b0);
      chk1(req, "idle out_wr_en", out_wr_en, 1'b0);
      chk1(req, "idle out_undef", out_undef, 1'b0);
   endtask

   function automatic logic [W-1:0] fill(input logic [31:0] seed);
      logic [W-1:0] v;
      logic [31:0]  x;
      x = seed;
      for (int i = 0; i < 8; i++) begin
         x = x * 32'd1664525 + 32'd1013904223;
         v[i*32 +: 32] = x;
      end
      return v;
   endfunction

   task automatic t_reset();
      rst = 1'b1; in_valid = 1'b1; in_mode = 2'b10; in_len = 1'b0;
      in_dst = '0; in_src1 = '0; in_src2 = '0;
      repeat (3) @(negedge clk);
      chk1("R11", "reset out_valid", out_valid, 1'b0);
      chk1("R11", "reset out_wr_en", out_wr_en, 1'b0);
      chk1("R11", "reset out_undef", out_undef, 1'b0);
      rst = 1'b0; in_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_extremes_R1();
      logic [W-1:0] a, b;
      for (int i = 0; i < 8; i++) begin
         a[i*32 +: 32] = (i % 2 == 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
         b[i*32 +: 32] = (i % 2 == 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
      end
      exec("R1", 2'b10, 1'b0, fill(32'd5), a, b);
      idle("R10");
   endtask

   task automatic t_rotating_sign_R1();
      for (int p = 0; p < 8; p++) begin
         logic [W-1:0] a, b;
         for (int i = 0; i < 8; i++) begin
            a[i*32 +: 32] = (i == p) ? 32'hFFFF_FFF0 : 32'h0000_0010 + i;
            b[i*32 +: 32] = (i == p) ? 32'h0000_0001 : 32'hFFFF_0000 - i;
         end
         exec("R1", 2'b10, 1'b0, '0, a, b);
      end
      idle("R10");
   endtask

   task automatic t_equal_R2();
      logic [W-1:0] a;
      for (int i = 0; i < 8; i++) a[i*32 +: 32] = (i < 4) ? 32'h8000_0000 : 32'h1234_5678 + i;
      exec("R2", 2'b10, 1'b0, '1, a, a);
      exec("R2", 2'b00, 1'b0, a, fill(32'd9), a);
      idle("R10");
   endtask

   task automatic t_legacy_R3();
      exec("R3", 2'b00, 1'b0, fill(32'd11), {8{32'hA5A5_0000}}, fill(32'd12));
      exec("R3", 2'b00, 1'b0, fill(32'd13), '1, fill(32'd14));
      idle("R10");
   endtask

   task automatic t_enc128_R4();
      exec("R4", 2'b01, 1'b0, fill(32'd21), fill(32'd22), fill(32'd23));
      idle("R10");
   endtask

   task automatic t_enc256_R5();
      for (int k = 0; k < 6; k++)
         exec("R5", 2'b10, 1'b0, fill(32'd40 + k), fill(32'd50 + k), fill(32'd60 + k));
      idle("R9");
   endtask

   task automatic t_len_undef_R6();
      exec("R6", 2'b01, 1'b1, fill(32'd71), fill(32'd72), fill(32'd73));
      idle("R10");
   endtask

   task automatic t_reserved_R7();
      exec("R7", 2'b11, 1'b0, fill(32'd81), fill(32'd82), fill(32'd83));
      exec("R7", 2'b11, 1'b1, fill(32'd84), '0, '0);
      idle("R10");
   endtask

   task automatic t_len_ignored_R8();
      exec("R8", 2'b00, 1'b1, fill(32'd91), fill(32'd92), fill(32'd93));
      exec("R8", 2'b10, 1'b1, fill(32'd94), fill(32'd95), fill(32'd96));
      idle("R10");
   endtask

   task automatic t_back_to_back_R9();
      exec("R9", 2'b10, 1'b0, '0, fill(32'd101), fill(32'd102));
      exec("R9", 2'b11, 1'b0, fill(32'd103), '0, '0);
      exec("R9", 2'b01, 1'b0, fill(32'd104), fill(32'd105), fill(32'd106));
      idle("R9");
   endtask

   initial begin
      t_reset();
      t_extremes_R1();
      t_rotating_sign_R1();
      t_equal_R2();
      t_legacy_R3();
      t_enc128_R4();
      t_enc256_R5();
      t_len_undef_R6();
      t_reserved_R7();
      t_len_ignored_R8();
      t_back_to_back_R9();
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule